// File: doc/BRIEF.md
# Integer Execute Unit with Shifter

This block is the integer execute stage of a 32-bit load/store core. Each cycle a decoder hands it an operation code, the two source register values, the instruction's 16-bit immediate, the 5-bit shift-amount field, the destination register index and one spare instruction field. The block returns the result together with a write-enable for the register file. Its outputs are registered, so the result appears one clock after the operation is issued.

The unit covers several groups of operations. The arithmetic group has wrapping add and subtract. The logic group has AND, OR, XOR and NOR, with immediate forms where they apply. The compare group has signed and unsigned set-less-than, and signed maximum and minimum. There are also two moves that depend on whether the second operand is zero, and shifts by either a constant or a register amount. Rotate-right has no code of its own: it takes the logical shift-right code and is selected by the spare field.

When an operation does not write, the write-enable stays low. This happens when the destination is register 0, when a conditional move fails, when the operation code is undefined, or when nothing is issued. The register file then keeps its previous contents.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `res` = 0 and `wr_en` = 0.
- R2: An operation with `issue` high shows its `res` and `wr_en` after exactly one rising clock edge. A cycle with `issue` low gives `wr_en` = 0 after that edge.
- R3: ADD (code 0) and SUB (code 1) return rs+rt and rs-rt modulo 2^XLEN and raise no overflow. ADDI (code 12) adds rs to the sign-extended immediate.
- R4: AND (2), OR (3), XOR (4) and NOR (5) act bitwise on rs and rt, and NOR gives ~(rs|rt). ANDI (15), ORI (16) and XORI (17) use the immediate zero-extended to XLEN.
- R5: LUI (18) places the immediate in the top IMM_W bits of the result and clears all lower bits.
- R6: SLT (6) compares rs and rt as signed values and SLTU (7) compares them as unsigned. SLTI (13) compares signed against the sign-extended immediate. SLTIU (14) compares unsigned against that same sign-extended immediate. Each gives a full-width result of 0 or 1.
- R7: MAX (8) returns the larger and MIN (9) the smaller of rs and rt, both compared in two's complement.
- R8: MOVZ (10) writes rs only when rt is 0, and MOVN (11) writes rs only when rt is nonzero. In the failing case `wr_en` is 0.
- R9: SLL (19), SRL (20) and SRA (21) shift rt by `shamt`. SRA fills the vacated bits with the sign bit of rt.
- R10: SLLV (22), SRLV (23) and SRAV (24) shift rt by the low log2(XLEN) bits of rs. The higher bits of rs are ignored.
- R11: On SRL and SRLV, a `rot_fld` value of exactly 1 turns the shift into a rotate-right of rt. Any other `rot_fld` value, including odd values other than 1, gives a logical shift.
- R12: When `dst_idx` is 0, `wr_en` stays 0 for every operation.
- R13: Codes 25 to 31 are undefined and give `wr_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An operation is present this cycle |
| op | input | 5 | Operation code |
| dst_idx | input | REG_W | Destination register index |
| rot_fld | input | FLD_W | Spare field; value 1 selects rotate on shift-right codes |
| rs_val | input | XLEN | First source operand |
| rt_val | input | XLEN | Second source operand |
| imm | input | IMM_W | Instruction immediate |
| shamt | input | log2(XLEN) | Constant shift amount |
| res | output | XLEN | Registered result |
| wr_en | output | 1 | Registered register-file write enable |

## Verification
The bench builds the unit with XLEN = 8 and IMM_W = 4, keeping REG_W and FLD_W at 5. At this width every value of rs can be swept for each of the 32 operation codes, paired with eight rt patterns that include zero, the sign boundaries, all-ones and rs itself. The same sweep reaches every shift distance, every wrap of add and subtract, and both immediate signs. The destination index, the issue bit and the rotate field (values 0, 1, 3 and 17) vary with rs, so suppressed writes and the exactly-1 rotate select are exercised inside the same sweep.

// File: rtl/ixu_pkg.sv
package ixu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_AND   = 5'd2,
    OP_OR    = 5'd3,
    OP_XOR   = 5'd4,
    OP_NOR   = 5'd5,
    OP_SLT   = 5'd6,
    OP_SLTU  = 5'd7,
    OP_MAX   = 5'd8,
    OP_MIN   = 5'd9,
    OP_MOVZ  = 5'd10,
    OP_MOVN  = 5'd11,
    OP_ADDI  = 5'd12,
    OP_SLTI  = 5'd13,
    OP_SLTIU = 5'd14,
    OP_ANDI  = 5'd15,
    OP_ORI   = 5'd16,
    OP_XORI  = 5'd17,
    OP_LUI   = 5'd18,
    OP_SLL   = 5'd19,
    OP_SRL   = 5'd20,
    OP_SRA   = 5'd21,
    OP_SLLV  = 5'd22,
    OP_SRLV  = 5'd23,
    OP_SRAV  = 5'd24
  } ixu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 5'd24;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2,
    SH_ROT   = 2'd3
  } sh_mode_e;
endpackage

// File: rtl/ixu_operand.sv
module ixu_operand
  import ixu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  ixu_op_e           op,
  input  logic [XLEN-1:0]   rt_val,
  input  logic [IMM_W-1:0]  imm,
  output logic [XLEN-1:0]   opb
);
  localparam int PAD = XLEN - IMM_W;

  logic [XLEN-1:0] imm_sx, imm_zx, imm_hi;

  assign imm_sx = {{PAD{imm[IMM_W-1]}}, imm};
  assign imm_zx = {{PAD{1'b0}}, imm};
  assign imm_hi = {imm, {PAD{1'b0}}};

  always_comb begin
    case (op)
      OP_ADDI, OP_SLTI, OP_SLTIU: opb = imm_sx;
      OP_ANDI, OP_ORI, OP_XORI:   opb = imm_zx;
      OP_LUI:                     opb = imm_hi;
      default:                    opb = rt_val;
    endcase
  end
endmodule

// File: rtl/ixu_arith.sv
module ixu_arith
  import ixu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ixu_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  y,
  output logic             cond_ok
);
  logic [XLEN-1:0] sum, diff;
  logic            lt_s, lt_u, b_zero;

  assign sum    = a + b;
  assign diff   = a - b;
  assign lt_s   = $signed(a) < $signed(b);
  assign lt_u   = a < b;
  assign b_zero = (b == '0);

  always_comb begin
    y       = '0;
    cond_ok = 1'b1;
    case (op)
      OP_ADD, OP_ADDI:  y = sum;
      OP_SUB:           y = diff;
      OP_AND, OP_ANDI:  y = a & b;
      OP_OR,  OP_ORI:   y = a | b;
      OP_XOR, OP_XORI:  y = a ^ b;
      OP_NOR:           y = ~(a | b);
      OP_SLT, OP_SLTI:  y = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU, OP_SLTIU: y = {{(XLEN-1){1'b0}}, lt_u};
      OP_MAX:           y = lt_s ? b : a;
      OP_MIN:           y = lt_s ? a : b;
      OP_MOVZ: begin
        y       = a;
        cond_ok = b_zero;
      end
      OP_MOVN: begin
        y       = a;
        cond_ok = !b_zero;
      end
      OP_LUI:           y = b;
      default:          y = '0;
    endcase
  end
endmodule

// File: rtl/ixu_shift.sv
module ixu_shift
  import ixu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int FLD_W = 5,
  parameter int SH_W  = $clog2(XLEN)
) (
  input  ixu_op_e           op,
  input  logic [FLD_W-1:0]  rot_fld,
  input  logic [SH_W-1:0]   const_amt,
  input  logic [SH_W-1:0]   reg_amt,
  input  logic [XLEN-1:0]   src,
  output logic [XLEN-1:0]   y,
  output logic              is_shift
);
  sh_mode_e        mode;
  logic [SH_W-1:0] amt;
  logic            rot_sel;
  logic            fill;
  logic [XLEN-1:0] stg [0:SH_W];

  assign rot_sel = (rot_fld == FLD_W'(1));
  assign fill    = src[XLEN-1];

  always_comb begin
    is_shift = 1'b1;
    mode     = SH_LEFT;
    amt      = const_amt;
    case (op)
      OP_SLL:  mode = SH_LEFT;
      OP_SRL:  mode = rot_sel ? SH_ROT : SH_RLOG;
      OP_SRA:  mode = SH_RARI;
      OP_SLLV: begin mode = SH_LEFT; amt = reg_amt; end
      OP_SRLV: begin mode = rot_sel ? SH_ROT : SH_RLOG; amt = reg_amt; end
      OP_SRAV: begin mode = SH_RARI; amt = reg_amt; end
      default: is_shift = 1'b0;
    endcase
  end

  assign stg[0] = src;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int D = 1 << i;
    always_comb begin
      if (!amt[i]) begin
        stg[i+1] = stg[i];
      end else begin
        case (mode)
          SH_LEFT: stg[i+1] = {stg[i][XLEN-1-D:0], {D{1'b0}}};
          SH_RLOG: stg[i+1] = {{D{1'b0}}, stg[i][XLEN-1:D]};
          SH_RARI: stg[i+1] = {{D{fill}}, stg[i][XLEN-1:D]};
          default: stg[i+1] = {stg[i][D-1:0], stg[i][XLEN-1:D]};
        endcase
      end
    end
  end

  assign y = stg[SH_W];
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import ixu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int REG_W = 5,
  parameter int FLD_W = 5,
  parameter int SH_W  = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [4:0]        op,
  input  logic [REG_W-1:0]  dst_idx,
  input  logic [FLD_W-1:0]  rot_fld,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SH_W-1:0]   shamt,
  output logic [XLEN-1:0]   res,
  output logic              wr_en
);
  localparam int PAD = XLEN - IMM_W;

  ixu_op_e         op_e;
  logic [XLEN-1:0] opb, ar_y, sh_y, nxt_res;
  logic            cond_ok, is_shift, legal, nxt_we;

  assign op_e  = ixu_op_e'(op);
  assign legal = (op <= OP_LAST);

  ixu_operand #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
    .op(op_e), .rt_val(rt_val), .imm(imm), .opb(opb)
  );

  ixu_arith #(.XLEN(XLEN)) u_arith (
    .op(op_e), .a(rs_val), .b(opb), .y(ar_y), .cond_ok(cond_ok)
  );

  ixu_shift #(.XLEN(XLEN), .FLD_W(FLD_W), .SH_W(SH_W)) u_shift (
    .op(op_e), .rot_fld(rot_fld), .const_amt(shamt),
    .reg_amt(rs_val[SH_W-1:0]), .src(rt_val),
    .y(sh_y), .is_shift(is_shift)
  );

  assign nxt_res = is_shift ? sh_y : ar_y;
  assign nxt_we  = issue && legal && cond_ok && (dst_idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      res   <= '0;
      wr_en <= 1'b0;
    end else begin
      res   <= nxt_res;
      wr_en <= nxt_we;
    end
  end

  p_rst_clear_r1: assert property (@(posedge clk)
    rst |=> (res == '0 && !wr_en));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !issue |=> !wr_en);

  p_lui_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (issue && op == OP_LUI) |=> (res[PAD-1:0] == '0));

  p_slt_bool_r6: assert property (@(posedge clk) disable iff (rst)
    (issue && (op == OP_SLT || op == OP_SLTU || op == OP_SLTI || op == OP_SLTIU))
      |=> (res[XLEN-1:1] == '0));

  p_max_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (issue && op == OP_MAX) |=>
      ($signed(res) >= $signed($past(rs_val)) && $signed(res) >= $signed($past(rt_val))));

  p_movz_block_r8: assert property (@(posedge clk) disable iff (rst)
    (issue && op == OP_MOVZ && rt_val != '0) |=> !wr_en);

  p_zero_dst_r12: assert property (@(posedge clk) disable iff (rst)
    (issue && dst_idx == '0) |=> !wr_en);

  p_undef_code_r13: assert property (@(posedge clk) disable iff (rst)
    (issue && op > OP_LAST) |=> !wr_en);
endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
  localparam int  XW     = 8;
  localparam int  IW     = 4;
  localparam int  SW     = 3;
  localparam time PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic          issue;
  logic [4:0]    op;
  logic [4:0]    dst_idx;
  logic [4:0]    rot_fld;
  logic [XW-1:0] rs_val, rt_val;
  logic [IW-1:0] imm;
  logic [SW-1:0] shamt;
  logic [XW-1:0] res;
  logic          wr_en;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  int_exec_unit #(.XLEN(XW), .IMM_W(IW), .REG_W(5), .FLD_W(5)) u0 (
    .clk(clk), .rst(rst), .issue(issue), .op(op), .dst_idx(dst_idx),
    .rot_fld(rot_fld), .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
    .shamt(shamt), .res(res), .wr_en(wr_en)
  );

  function automatic string req_of(input logic [4:0] c, input logic [4:0] rf);
    if (c == 0 || c == 1 || c == 12) return "R3";
    if ((c >= 2 && c <= 5) || (c >= 15 && c <= 17)) return "R4";
    if (c == 18) return "R5";
    if (c == 6 || c == 7 || c == 13 || c == 14) return "R6";
    if (c == 8 || c == 9) return "R7";
    if (c == 10 || c == 11) return "R8";
    if ((c == 20 || c == 23) && rf == 5'd1) return "R11";
    if (c >= 19 && c <= 21) return "R9";
    if (c >= 22 && c <= 24) return "R10";
    return "R13";
  endfunction

  function automatic logic [XW-1:0] rotr(input logic [XW-1:0] v, input int s);
    logic [2*XW-1:0] d;
    d = {v, v} >> s;
    return d[XW-1:0];
  endfunction

  // Reference model computed from the requirements
  function automatic logic [XW:0] model(input logic [4:0] c, input logic [XW-1:0] a,
      input logic [XW-1:0] b, input logic [IW-1:0] im, input logic [SW-1:0] sh,
      input logic [4:0] rf);
    logic [XW-1:0] se, ze, r;
    logic ok;
    int va;
    se = XW'($signed(im));
    ze = XW'(im);
    va = int'(a % XW);
    ok = 1'b1;
    r  = '0;
    case (c)
      0:  r = a + b;
      1:  r = a - b;
      2:  r = a & b;
      3:  r = a | b;
      4:  r = a ^ b;
      5:  r = ~(a | b);
      6:  r = ($signed(a) < $signed(b)) ? 1 : 0;
      7:  r = (a < b) ? 1 : 0;
      8:  r = ($signed(a) > $signed(b)) ? a : b;
      9:  r = ($signed(a) < $signed(b)) ? a : b;
      10: begin r = a; ok = (b == 0); end
      11: begin r = a; ok = (b != 0); end
      12: r = a + se;
      13: r = ($signed(a) < $signed(se)) ? 1 : 0;
      14: r = (a < se) ? 1 : 0;
      15: r = a & ze;
      16: r = a | ze;
      17: r = a ^ ze;
      18: r = {im, {(XW-IW){1'b0}}};
      19: r = b << sh;
      20: r = (rf == 1) ? rotr(b, int'(sh)) : b >> sh;
      21: r = XW'($signed(b) >>> sh);
      22: r = b << va;
      23: r = (rf == 1) ? rotr(b, va) : b >> va;
      24: r = XW'($signed(b) >>> va);
      default: ok = 1'b0;
    endcase
    return {ok, r};
  endfunction

  function automatic logic [XW-1:0] pick_b(input int k, input logic [XW-1:0] a);
    case (k)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h7f;
      3: return 8'h80;
      4: return 8'hff;
      5: return a;
      6: return ~a;
      default: return a * 8'd37 + 8'd11;
    endcase
  endfunction

  task automatic chk(input string rq, input logic [XW-1:0] got, input logic [XW-1:0] exp,
      input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, got, exp);
    end
  endtask

  initial begin : watchdog
    #(PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [XW:0] m;
    logic        exp_we;
    rst = 1'b1; issue = 1'b0; op = '0; dst_idx = '0; rot_fld = '0;
    rs_val = '0; rt_val = '0; imm = '0; shamt = '0;
    repeat (3) @(negedge clk);
    chk("R1", res, '0, "reset res");
    chk("R1", XW'(wr_en), '0, "reset wr_en");
    rst = 1'b0;

    for (int c = 0; c < 32; c++) begin
      for (int av = 0; av < 256; av++) begin
        for (int k = 0; k < 8; k++) begin
          op      = 5'(c);
          rs_val  = XW'(av);
          rt_val  = pick_b(k, XW'(av));
          imm     = rt_val[IW-1:0] ^ rs_val[7:4];
          shamt   = rt_val[SW-1:0] ^ 3'(k);
          case (av % 4)
            1:       rot_fld = 5'd1;
            2:       rot_fld = 5'd3;
            3:       rot_fld = 5'd17;
            default: rot_fld = 5'd0;
          endcase
          dst_idx = (av == 3 || av == 200) ? 5'd0 : 5'd9;
          issue   = !(av == 7 || av == 130);
          m = model(op, rs_val, rt_val, imm, shamt, rot_fld);
          exp_we = issue && m[XW] && (dst_idx != 0);
          @(negedge clk);
          if (!issue)
            chk("R2", XW'(wr_en), XW'(exp_we), "idle wr_en");
          else if (dst_idx == 0)
            chk("R12", XW'(wr_en), 8'h00, "zero dst wr_en");
          else
            chk(req_of(op, rot_fld), XW'(wr_en), XW'(exp_we), "wr_en");
          if (issue && m[XW])
            chk(req_of(op, rot_fld), res, m[XW-1:0], "res");
        end
      end
    end

    // R10: upper bits of the register amount are ignored
    op = 5'd22; rs_val = 8'hF9; rt_val = 8'h03; dst_idx = 5'd4; rot_fld = 5'd0; issue = 1'b1;
    @(negedge clk);
    chk("R10", res, 8'h06, "sllv high bits ignored");

    // R1: reset mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R1", res, '0, "reset res late");
    chk("R1", XW'(wr_en), '0, "reset wr_en late");
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule